// File: doc/BRIEF.md
# Static LCD Three-and-a-Half Digit Segment Driver

This block drives a direct-drive (static) liquid-crystal panel that shows a reading of up to 1999 with a minus sign. It receives a held reading: three BCD digits, a single leading-one flag and a polarity flag. It also receives a lamp-test level. From these it produces a common backplane square wave and one drive line per segment.

The backplane is a 50% duty square wave made by dividing the block clock. Each segment line copies the backplane when the segment is dark and carries its complement when the segment is lit, so a dark segment sees no voltage and a lit one sees a symmetric AC voltage. The lit pattern is taken from the inputs only on the clock edge where the backplane toggles, so a new reading never changes a line partway through a half period. Lamp test overrides the reading and holds every segment line at a steady high level, which shows 1888 with the sign lit.

The reading inputs are plain level inputs with no handshake. The reading is held upstream, and this block samples it once per backplane half period, so it never applies back-pressure.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp` is a square wave with a period of `BP_DIV` clocks. It toggles on every `BP_DIV/2`-th rising clock edge after reset is released, so it is 0 after edges 1..`BP_DIV/2`-1 and first goes to 1 on edge `BP_DIV/2`.
- R2: While reset is asserted, and until the first backplane toggle after it, `bp` and every segment output are 0.
- R3: A dark segment output equals `bp` in every cycle.
- R4: A lit segment output equals the inverse of `bp` in every cycle.
- R5: Each full digit uses this bit map: bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g. The lit codes are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F (hex). The values 10 to 15 light nothing.
- R6: `seg_kilo` drives the joined b and c segments of the leading position. It is lit only when `kilo_one` is 1 and dark when it is 0.
- R7: `seg_sign` is lit only when `negative` is 1.
- R8: When `lamp_test` is 1 at a rising edge, every segment output is 1 after that edge and holds steady while `bp` keeps toggling. Normal drive resumes on the edge after `lamp_test` returns to 0.
- R9: The lit pattern is sampled from the reading inputs only on the edges where `bp` toggles. A change of the inputs between two such edges does not alter any segment output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| units_bcd | input | 4 | Units digit, BCD |
| tens_bcd | input | 4 | Tens digit, BCD |
| hunds_bcd | input | 4 | Hundreds digit, BCD |
| kilo_one | input | 1 | Leading position shows 1 |
| negative | input | 1 | Reading is negative |
| lamp_test | input | 1 | Force all segments on, steady level |
| bp | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units segments a..g (bit0..bit6) |
| seg_tens | output | 7 | Tens segments a..g |
| seg_hunds | output | 7 | Hundreds segments a..g |
| seg_kilo | output | 1 | Leading-one segment pair |
| seg_sign | output | 1 | Minus sign segment |

## Verification
Every digit value from 0 to 15 is tried in each position. This separates the ten real codes from each other and from blanking. An all-eights reading with both flags set lights every line, so each line must be the inverse of the backplane. A reading of invalid codes with both flags clear darkens every line, so each line must match the backplane. A reading changed in the middle of a half period shows whether the pattern is held until the next toggle. Lamp test is held across a toggle to show that the lines stay steady while the backplane moves, and it is released mid half period to show that normal drive returns at once.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg7_t;

  // bit0=a ... bit6=g ; values above nine blank
  function automatic seg7_t bcd_to_seg(input logic [3:0] d);
    seg7_t s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd_bp_timer.sv
module lcd_bp_timer #(
  parameter int BP_DIV = 800
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic bp
);
  localparam int HALF  = BP_DIV / 2;
  localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      bp  <= ~bp;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: backplane only moves on the divider terminal count
  assert_bp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bp));
  assert_bp_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (bp != $past(bp)));
endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
  import lcd_drv_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic [DIGITS*4-1:0]       bcd,
  input  logic                      kilo_one,
  input  logic                      negative,
  output logic [DIGITS*SEG_W+1:0]   pattern
);
  localparam int NSEG = DIGITS * SEG_W + 2;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] d;
    assign d = bcd[i*4 +: 4];
    assign pattern[i*SEG_W +: SEG_W] = bcd_to_seg(d);

    // R5: out-of-range codes must leave the digit dark
    always_comb begin
      if (d > 4'd9) begin
        assert_blank_R5: assert (pattern[i*SEG_W +: SEG_W] == '0);
      end
    end
  end

  assign pattern[NSEG-2] = kilo_one;
  assign pattern[NSEG-1] = negative;
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
  parameter int NSEG = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            bp,
  input  logic            lamp_test,
  input  logic [NSEG-1:0] pattern,
  output logic [NSEG-1:0] seg
);
  logic [NSEG-1:0] lit_q;
  logic [NSEG-1:0] lit_next;
  logic            bp_next;

  assign lit_next = tick ? pattern : lit_q;
  assign bp_next  = bp ^ tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q <= '0;
      seg   <= '0;
    end else begin
      lit_q <= lit_next;
      if (lamp_test) seg <= '1;
      else           seg <= lit_next ^ {NSEG{bp_next}};
    end
  end

  // R9: held pattern changes only at a backplane edge
  assert_lit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lit_q));
  // R9: without a toggle or lamp change, segment lines do not move
  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !lamp_test && !$past(lamp_test)) |=> $stable(seg));
  // R8: lamp test drives every line high
  assert_lamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test |=> (&seg));
endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
  import lcd_drv_pkg::*;
#(
  parameter int BP_DIV = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] units_bcd,
  input  logic [3:0] tens_bcd,
  input  logic [3:0] hunds_bcd,
  input  logic       kilo_one,
  input  logic       negative,
  input  logic       lamp_test,
  output logic       bp,
  output logic [6:0] seg_units,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_hunds,
  output logic       seg_kilo,
  output logic       seg_sign
);
  localparam int DIGITS = 3;
  localparam int NSEG   = DIGITS * SEG_W + 2;

  logic            tick;
  logic [NSEG-1:0] pattern;
  logic [NSEG-1:0] seg;

  lcd_bp_timer #(.BP_DIV(BP_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .bp    (bp)
  );

  lcd_seg_decode #(.DIGITS(DIGITS)) u_decode (
    .bcd      ({hunds_bcd, tens_bcd, units_bcd}),
    .kilo_one (kilo_one),
    .negative (negative),
    .pattern  (pattern)
  );

  lcd_seg_drive #(.NSEG(NSEG)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bp        (bp),
    .lamp_test (lamp_test),
    .pattern   (pattern),
    .seg       (seg)
  );

  assign seg_units = seg[0*SEG_W +: SEG_W];
  assign seg_tens  = seg[1*SEG_W +: SEG_W];
  assign seg_hunds = seg[2*SEG_W +: SEG_W];
  assign seg_kilo  = seg[NSEG-2];
  assign seg_sign  = seg[NSEG-1];

  // R7: a negative reading sampled at a toggle lights the sign line against bp
  assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lamp_test && negative) |=> (seg_sign != bp));
  // R6: a cleared leading flag sampled at a toggle leaves its line with bp
  assert_kilo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lamp_test && !kilo_one) |=> (seg_kilo == bp));
endmodule

// File: tb/lcd_static_driver_tb.sv
module lcd_static_driver_tb;
  localparam int BP_DIV = 16;
  localparam int HALF   = BP_DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] units_bcd = 4'd0, tens_bcd = 4'd0, hunds_bcd = 4'd0;
  logic kilo_one = 1'b0, negative = 1'b0, lamp_test = 1'b0;
  logic bp, seg_kilo, seg_sign;
  logic [6:0] seg_units, seg_tens, seg_hunds;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lcd_static_driver #(.BP_DIV(BP_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .units_bcd(units_bcd), .tens_bcd(tens_bcd),
    .hunds_bcd(hunds_bcd), .kilo_one(kilo_one), .negative(negative),
    .lamp_test(lamp_test), .bp(bp), .seg_units(seg_units), .seg_tens(seg_tens),
    .seg_hunds(seg_hunds), .seg_kilo(seg_kilo), .seg_sign(seg_sign)
  );

  // per-segment digit sets, bit n set = segment lit for digit n
  function automatic logic [6:0] ref_digit(input int d);
    logic [9:0] m [7];
    logic [6:0] r;
    m[0] = 10'b1111101101; m[1] = 10'b1110011111; m[2] = 10'b1111111011;
    m[3] = 10'b1101101101; m[4] = 10'b0101000101; m[5] = 10'b1101110001;
    m[6] = 10'b1101111100;
    for (int s = 0; s < 7; s++) r[s] = (d < 10) ? m[s][d] : 1'b0;
    return r;
  endfunction

  function automatic logic [22:0] outs();
    return {seg_sign, seg_kilo, seg_hunds, seg_tens, seg_units};
  endfunction

  // behavioural reference
  int m_cnt = 0;
  logic m_bp = 1'b0;
  logic [22:0] m_lit = '0;
  logic [22:0] m_seg = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_bp = 1'b0; m_lit = '0; m_seg = '0;
    end else begin
      if (m_cnt == HALF - 1) begin
        m_cnt = 0;
        m_bp = ~m_bp;
        m_lit = {negative, kilo_one, ref_digit(int'(hunds_bcd)),
                 ref_digit(int'(tens_bcd)), ref_digit(int'(units_bcd))};
      end else begin
        m_cnt++;
      end
      m_seg = lamp_test ? '1 : (m_lit ^ {23{m_bp}});
    end
  end

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1", {22'd0, bp}, {22'd0, m_bp});
      check(lamp_test ? "R8" : "R5", outs(), m_seg);
    end
  end

  task automatic set_reading(input int h, input int t, input int u, input bit k, input bit n);
    hunds_bcd = 4'(h); tens_bcd = 4'(t); units_bcd = 4'(u);
    kilo_one = k; negative = n;
  endtask

  // wait until just after a backplane toggle edge
  task automatic after_toggle();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [22:0] held;
    repeat (3) @(negedge clk);
    check("R2", {outs(), bp} == '0 ? 24'd0 : 24'd1, 24'd0);
    set_reading(1, 2, 3, 1, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", {1'b0, outs()}, 24'd0);
    after_toggle();
    check("R1", {22'd0, bp}, 23'd1);
    check("R6", {22'd0, seg_kilo}, {22'd0, ~bp});
    check("R7", {22'd0, seg_sign}, {22'd0, bp});

    // sweep each code through every position
    for (int v = 0; v < 16; v++) begin
      set_reading(v, (v + 5) % 16, (v + 11) % 16, v[0], v[1]);
      after_toggle();
      after_toggle();
      check("R5", {16'd0, seg_units}, {16'd0, ref_digit((v + 11) % 16) ^ {7{bp}}});
    end

    // everything lit: lines are inverse of bp
    set_reading(8, 8, 8, 1, 1);
    after_toggle();
    check("R4", outs(), ~{23{bp}});
    check("R7", {22'd0, seg_sign}, {22'd0, ~bp});
    after_toggle();
    check("R4", outs(), ~{23{bp}});

    // everything dark: lines follow bp
    set_reading(15, 12, 10, 0, 0);
    after_toggle();
    check("R3", outs(), {23{bp}});
    check("R6", {22'd0, seg_kilo}, {22'd0, bp});
    after_toggle();
    check("R3", outs(), {23{bp}});

    // mid-half-period change is not visible until next toggle
    set_reading(4, 5, 6, 1, 0);
    after_toggle();
    repeat (2) @(negedge clk);
    held = outs();
    set_reading(9, 0, 7, 0, 1);
    repeat (3) @(negedge clk);
    check("R9", outs(), held);
    after_toggle();
    check("R9", {16'd0, seg_units}, {16'd0, ref_digit(7) ^ {7{bp}}});

    // lamp test across a toggle, released mid half period
    repeat (2) @(negedge clk);
    lamp_test = 1'b1;
    @(negedge clk);
    check("R8", outs(), '1);
    held = {22'd0, bp};
    after_toggle();
    check("R8", outs(), '1);
    check("R8", {22'd0, bp}, ~held & 23'd1);
    repeat (3) @(negedge clk);
    lamp_test = 1'b0;
    @(negedge clk);
    check("R8", outs(), m_seg);

    repeat (3 * BP_DIV) @(negedge clk);
    finish_run();
  end
endmodule